// File: doc/BRIEF.md
# Lane-Parallel Register File and Operand Router

This block holds the working registers of one 16-lane half-precision processing unit that sits beside a memory bank, and steers operands to and results from that unit. Each cycle at most one command arrives, carrying an operation code, up to two operand selectors, a destination selector, a rectify flag and a flag that marks the triggering memory access as a write. Operands are taken from the bank read bus, from a wide vector register, from a narrow scalar register broadcast to every lane, or from the result of the previous command.

The vector store has sixteen 256-bit entries in two halves of eight. The scalar store has sixteen 16-bit entries in an additive half and a multiplicative half. Results go back to a vector register, a scalar register or the bank write bus, depending on the operation. The floating-point datapath is not part of this block. A lane-wise integer adder stands in for every arithmetic operation, so that routing can be checked with exact values.

Top module: `pu_operand_router`

## Requirements
- R1: While reset is held, and after it is released, `res_bus` and `bank_wdata` are zero and `bank_wvalid` is low until a command changes them.
- R2: Lane i occupies bits [16i+15:16i] of every 256-bit word. A move (op 1) from the bank (source 0) to vector half A (dest 0) or half B (dest 1), at entry 0..7, stores the bank word. A later read of that entry returns it unchanged.
- R3: A move to scalar half add (dest 2) or mul (dest 3) stores lane 0 of the moved word. Reading scalar source add (3) or mul (4) yields that 16-bit value repeated in all 16 lanes. The two halves are independent.
- R4: With `relu` set on a move (op 1) or fill (op 2), every lane whose bit 15 is set (including 0x8000) becomes 0x0000 and the other lanes pass unchanged. On arithmetic ops the flag has no effect.
- R5: Arithmetic ops add (3), mul (4) and mad (5 is mac, 6 is mad) produce the lane-wise sum of operand 0 and operand 1 modulo 2^16. For add, mul and mad the sum is written to the selected entry of half A or half B.
- R6: Mac (op 5) always writes its result to half B at `dst_idx`, whatever `dst_sel` says. Half A at that index is left untouched.
- R7: Source 5 reads the value `res_bus` holds, which is the output of the most recent command with op 1..6.
- R8: A fill (op 2) to the bank (dest 4) with `cmd_wr` high puts the value on `bank_wdata` and raises `bank_wvalid` for exactly the following cycle. Without `cmd_wr` it raises no valid and changes no register.
- R9: A destination an op cannot reach is ignored: move to bank, fill to a scalar half, arithmetic to a scalar half or to the bank. Such a command writes no register and raises no valid. It still updates `res_bus`.
- R10: With `op_valid` low, or with op 0 (no-op), no register changes and `res_bus` holds.
- R11: `bank_wdata` holds its last value in every cycle in which `bank_wvalid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Command present this cycle |
| op_code | input | 3 | 0 nop, 1 move, 2 fill, 3 add, 4 mul, 5 mac, 6 mad |
| dst_sel | input | 3 | 0 vec A, 1 vec B, 2 scalar add, 3 scalar mul, 4 bank |
| dst_idx | input | 3 | Destination entry within its half |
| src0_sel | input | 3 | 0 bank, 1 vec A, 2 vec B, 3 scalar add, 4 scalar mul, 5 previous result |
| src0_idx | input | 3 | Operand 0 entry |
| src1_sel | input | 3 | Operand 1 source, same coding as src0_sel |
| src1_idx | input | 3 | Operand 1 entry |
| relu | input | 1 | Clamp negative lanes on move and fill |
| cmd_wr | input | 1 | Triggering memory access is a write |
| bank_rdata | input | 256 | Bank read data for this command |
| bank_wdata | output | 256 | Registered bank write data |
| bank_wvalid | output | 1 | Bank write data valid, one cycle |
| res_bus | output | 256 | Registered result of the last command |

## Verification
A corrupted vector or scalar entry does not show at the ports when it is written. It shows only when a later command reads that entry, either in `res_bus` one cycle after the move or arithmetic that uses it, or in `bank_wdata` one cycle after a fill to the bank. The bench therefore writes every entry of both halves of both stores and reads each one back. A write that goes to the wrong half or index shows up as a mismatch on the entry it overwrote. A misrouted write valid shows at once: `bank_wvalid` is high in a cycle that no write fill caused.

// File: rtl/pu_router_pkg.sv
package pu_router_pkg;

  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_MOV  = 3'd1,
    OP_FILL = 3'd2,
    OP_ADD  = 3'd3,
    OP_MUL  = 3'd4,
    OP_MAC  = 3'd5,
    OP_MAD  = 3'd6
  } op_e;

  typedef enum logic [2:0] {
    SRC_BANK   = 3'd0,
    SRC_VEC_A  = 3'd1,
    SRC_VEC_B  = 3'd2,
    SRC_SCL_AD = 3'd3,
    SRC_SCL_MU = 3'd4,
    SRC_RESULT = 3'd5
  } src_e;

  typedef enum logic [2:0] {
    DST_VEC_A  = 3'd0,
    DST_VEC_B  = 3'd1,
    DST_SCL_AD = 3'd2,
    DST_SCL_MU = 3'd3,
    DST_BANK   = 3'd4
  } dst_e;

  function automatic logic op_is_arith(logic [2:0] op);
    return (op == OP_ADD) || (op == OP_MUL) || (op == OP_MAC) || (op == OP_MAD);
  endfunction

  function automatic logic op_is_active(logic [2:0] op);
    return (op >= OP_MOV) && (op <= OP_MAD);
  endfunction

endpackage

// File: rtl/pu_vec_store.sv
module pu_vec_store #(
  parameter int WORD_W     = 256,
  parameter int HALF_DEPTH = 8,
  parameter int IDX_W      = $clog2(HALF_DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic              w_half,
  input  logic [IDX_W-1:0]  w_idx,
  input  logic [WORD_W-1:0] w_data,
  input  logic              ra_half,
  input  logic [IDX_W-1:0]  ra_idx,
  output logic [WORD_W-1:0] ra_data,
  input  logic              rb_half,
  input  logic [IDX_W-1:0]  rb_idx,
  output logic [WORD_W-1:0] rb_data
);
  localparam int DEPTH = 2 * HALF_DEPTH;

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[{w_half, w_idx}] <= w_data;
  end

  assign ra_data = mem[{ra_half, ra_idx}];
  assign rb_data = mem[{rb_half, rb_idx}];
endmodule

// File: rtl/pu_scalar_store.sv
module pu_scalar_store #(
  parameter int LANES      = 16,
  parameter int LANE_W     = 16,
  parameter int HALF_DEPTH = 8,
  parameter int IDX_W      = $clog2(HALF_DEPTH)
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic                    w_mul,
  input  logic [IDX_W-1:0]        w_idx,
  input  logic [LANE_W-1:0]       w_data,
  input  logic                    ra_mul,
  input  logic [IDX_W-1:0]        ra_idx,
  output logic [LANES*LANE_W-1:0] ra_vec,
  input  logic                    rb_mul,
  input  logic [IDX_W-1:0]        rb_idx,
  output logic [LANES*LANE_W-1:0] rb_vec
);
  localparam int DEPTH = 2 * HALF_DEPTH;

  logic [LANE_W-1:0] mem [DEPTH];
  logic [LANE_W-1:0] ra_scl, rb_scl;

  always_ff @(posedge clk) begin
    if (we) mem[{w_mul, w_idx}] <= w_data;
  end

  assign ra_scl = mem[{ra_mul, ra_idx}];
  assign rb_scl = mem[{rb_mul, rb_idx}];

  for (genvar g = 0; g < LANES; g++) begin : g_bcast
    assign ra_vec[g*LANE_W +: LANE_W] = ra_scl;
    assign rb_vec[g*LANE_W +: LANE_W] = rb_scl;
  end
endmodule

// File: rtl/pu_lane_ops.sv
module pu_lane_ops #(
  parameter int LANES  = 16,
  parameter int LANE_W = 16
) (
  input  logic [LANES*LANE_W-1:0] a,
  input  logic [LANES*LANE_W-1:0] b,
  input  logic                    relu_en,
  input  logic                    sel_sum,
  output logic [LANES*LANE_W-1:0] y
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] a_l, b_l, sum_l, pass_l;
    assign a_l    = a[g*LANE_W +: LANE_W];
    assign b_l    = b[g*LANE_W +: LANE_W];
    // Stand-in for the floating-point unit: wrapping lane-wise add.
    assign sum_l  = a_l + b_l;
    // Rectify on sign bit only, so negative zero is cleared too.
    assign pass_l = (relu_en && a_l[LANE_W-1]) ? '0 : a_l;
    assign y[g*LANE_W +: LANE_W] = sel_sum ? sum_l : pass_l;

    // R4: a rectified move never leaves a lane with its sign bit set
    always_comb begin
      if (relu_en && !sel_sum) begin
        p_relu_sign_r4: assert (y[g*LANE_W + LANE_W - 1] == 1'b0);
      end
    end
  end
endmodule

// File: rtl/pu_operand_router.sv
module pu_operand_router
  import pu_router_pkg::*;
#(
  parameter int LANES      = 16,
  parameter int LANE_W     = 16,
  parameter int HALF_DEPTH = 8,
  localparam int WORD_W    = LANES * LANE_W,
  localparam int IDX_W     = $clog2(HALF_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [2:0]        op_code,
  input  logic [2:0]        dst_sel,
  input  logic [IDX_W-1:0]  dst_idx,
  input  logic [2:0]        src0_sel,
  input  logic [IDX_W-1:0]  src0_idx,
  input  logic [2:0]        src1_sel,
  input  logic [IDX_W-1:0]  src1_idx,
  input  logic              relu,
  input  logic              cmd_wr,
  input  logic [WORD_W-1:0] bank_rdata,
  output logic [WORD_W-1:0] bank_wdata,
  output logic              bank_wvalid,
  output logic [WORD_W-1:0] res_bus
);

  logic [WORD_W-1:0] vec_rd0, vec_rd1, scl_rd0, scl_rd1;
  logic [WORD_W-1:0] opnd0, opnd1, lane_y;
  logic active, arith, is_mov, is_fill, is_mac;
  logic vec_we, vec_half, scl_we, scl_mul, bank_we;

  assign active  = op_valid && op_is_active(op_code);
  assign arith   = op_is_arith(op_code);
  assign is_mov  = (op_code == OP_MOV);
  assign is_fill = (op_code == OP_FILL);
  assign is_mac  = (op_code == OP_MAC);

  function automatic logic [WORD_W-1:0] pick(
    logic [2:0] sel, logic [WORD_W-1:0] bank, logic [WORD_W-1:0] vec,
    logic [WORD_W-1:0] scl, logic [WORD_W-1:0] prev);
    case (sel)
      SRC_BANK:               return bank;
      SRC_VEC_A, SRC_VEC_B:   return vec;
      SRC_SCL_AD, SRC_SCL_MU: return scl;
      SRC_RESULT:             return prev;
      default:                return '0;
    endcase
  endfunction

  assign opnd0 = pick(src0_sel, bank_rdata, vec_rd0, scl_rd0, res_bus);
  assign opnd1 = pick(src1_sel, bank_rdata, vec_rd1, scl_rd1, res_bus);

  pu_vec_store #(.WORD_W(WORD_W), .HALF_DEPTH(HALF_DEPTH), .IDX_W(IDX_W)) u_vec (
    .clk     (clk),
    .we      (vec_we),
    .w_half  (vec_half),
    .w_idx   (dst_idx),
    .w_data  (lane_y),
    .ra_half (src0_sel == SRC_VEC_B),
    .ra_idx  (src0_idx),
    .ra_data (vec_rd0),
    .rb_half (src1_sel == SRC_VEC_B),
    .rb_idx  (src1_idx),
    .rb_data (vec_rd1)
  );

  pu_scalar_store #(.LANES(LANES), .LANE_W(LANE_W), .HALF_DEPTH(HALF_DEPTH), .IDX_W(IDX_W)) u_scl (
    .clk    (clk),
    .we     (scl_we),
    .w_mul  (scl_mul),
    .w_idx  (dst_idx),
    .w_data (lane_y[LANE_W-1:0]),
    .ra_mul (src0_sel == SRC_SCL_MU),
    .ra_idx (src0_idx),
    .ra_vec (scl_rd0),
    .rb_mul (src1_sel == SRC_SCL_MU),
    .rb_idx (src1_idx),
    .rb_vec (scl_rd1)
  );

  pu_lane_ops #(.LANES(LANES), .LANE_W(LANE_W)) u_ops (
    .a       (opnd0),
    .b       (opnd1),
    .relu_en (relu && (is_mov || is_fill)),
    .sel_sum (arith),
    .y       (lane_y)
  );

  // Destination decode: mac is pinned to half B, other ops honour dst_sel
  always_comb begin
    logic to_vec;
    to_vec   = (dst_sel == DST_VEC_A) || (dst_sel == DST_VEC_B);
    vec_we   = active && (is_mac || ((arith || is_mov || is_fill) && to_vec));
    vec_half = is_mac || (dst_sel == DST_VEC_B);
    scl_we   = active && is_mov && ((dst_sel == DST_SCL_AD) || (dst_sel == DST_SCL_MU));
    scl_mul  = (dst_sel == DST_SCL_MU);
    bank_we  = active && is_fill && (dst_sel == DST_BANK) && cmd_wr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_bus     <= '0;
      bank_wdata  <= '0;
      bank_wvalid <= 1'b0;
    end else begin
      bank_wvalid <= bank_we;
      if (bank_we) bank_wdata <= lane_y;
      if (active)  res_bus    <= lane_y;
    end
  end

  // R8: a valid bank write always traces back to a write-flagged fill to the bank
  p_wvalid_cause_r8: assert property (@(posedge clk) disable iff (rst)
    bank_wvalid |-> $past(op_valid && op_code == OP_FILL && dst_sel == DST_BANK && cmd_wr));

  // R11: write data is frozen whenever valid is low
  p_wdata_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !bank_wvalid |-> $stable(bank_wdata));

  // R10: idle or no-op cycles leave the result bus alone
  p_res_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !(op_valid && op_code >= OP_MOV && op_code <= OP_MAD) |=> $stable(res_bus));

  // R8: an idle cycle after a write leaves valid low
  p_wvalid_single_r8: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> !bank_wvalid);

endmodule

// File: tb/pu_operand_router_bench.sv
module pu_operand_router_bench;
  localparam int W = 256;
  localparam logic [2:0] NOP=0, MOV=1, FILL=2, ADD=3, MUL=4, MAC=5, MAD=6;
  localparam logic [2:0] D_A=0, D_B=1, D_SA=2, D_SM=3, D_BK=4;
  localparam logic [2:0] S_BK=0, S_A=1, S_B=2, S_SA=3, S_SM=4, S_RES=5;

  logic clk = 0, rst = 1;
  logic op_valid = 0, relu = 0, cmd_wr = 0;
  logic [2:0] op_code = 0, dst_sel = 0, dst_idx = 0, src0_sel = 0, src0_idx = 0, src1_sel = 0, src1_idx = 0;
  logic [W-1:0] bank_rdata = '0, bank_wdata, res_bus;
  logic bank_wvalid;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [W-1:0] vecm [16];
  logic [15:0]  sclm [16];

  always #2 clk = ~clk;

  pu_operand_router u_pu_operand_router (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code), .dst_sel(dst_sel),
    .dst_idx(dst_idx), .src0_sel(src0_sel), .src0_idx(src0_idx), .src1_sel(src1_sel),
    .src1_idx(src1_idx), .relu(relu), .cmd_wr(cmd_wr), .bank_rdata(bank_rdata),
    .bank_wdata(bank_wdata), .bank_wvalid(bank_wvalid), .res_bus(res_bus));

  function automatic logic [W-1:0] pat(int s);
    logic [W-1:0] v;
    for (int l = 0; l < 16; l++) v[l*16 +: 16] = 16'((s * 16'h0317 + l * 16'h0101 + 16'h0040) & 16'h7fff);
    return v;
  endfunction
  function automatic logic [W-1:0] lsum(logic [W-1:0] a, logic [W-1:0] b);
    logic [W-1:0] v;
    for (int l = 0; l < 16; l++) v[l*16 +: 16] = a[l*16 +: 16] + b[l*16 +: 16];
    return v;
  endfunction
  function automatic logic [W-1:0] rectify(logic [W-1:0] a);
    logic [W-1:0] v;
    for (int l = 0; l < 16; l++) v[l*16 +: 16] = a[l*16+15] ? 16'h0000 : a[l*16 +: 16];
    return v;
  endfunction
  function automatic logic [W-1:0] rep(logic [15:0] s);
    return {16{s}};
  endfunction

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(logic [2:0] op, logic [2:0] ds, logic [2:0] di, logic [2:0] s0, logic [2:0] s0i,
                       logic [2:0] s1, logic [2:0] s1i, logic rl, logic wr, logic [W-1:0] bd);
    @(negedge clk);
    op_valid = 1; op_code = op; dst_sel = ds; dst_idx = di; src0_sel = s0; src0_idx = s0i;
    src1_sel = s1; src1_idx = s1i; relu = rl; cmd_wr = wr; bank_rdata = bd;
    @(posedge clk); #1;
    op_valid = 0;
  endtask

  // read a vector entry out through a write fill to the bank
  task automatic peek_vec(string tag, int e, logic [W-1:0] exp);
    issue(FILL, D_BK, 3'(e % 8), (e >= 8) ? S_B : S_A, 3'(e % 8), S_BK, 0, 0, 1, '0);
    chk(tag, W'(bank_wvalid), W'(1));
    chk(tag, bank_wdata, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] v, hold, prev;
    repeat (4) @(posedge clk);
    #1;
    chk("R1 res", res_bus, '0); chk("R1 wvalid", W'(bank_wvalid), '0); chk("R1 wdata", bank_wdata, '0);
    @(negedge clk); rst = 0;
    @(posedge clk); #1;
    chk("R1 after release", res_bus | W'(bank_wvalid), '0);

    // R2: fill all sixteen vector entries from the bank
    for (int e = 0; e < 16; e++) begin
      vecm[e] = pat(e);
      issue(MOV, (e >= 8) ? D_B : D_A, 3'(e % 8), S_BK, 0, S_BK, 0, 0, 0, pat(e));
      chk("R2 move result", res_bus, pat(e));
    end
    for (int e = 0; e < 16; e++) peek_vec("R2 readback", e, vecm[e]);
    hold = bank_wdata;
    @(negedge clk); @(posedge clk); #1;
    chk("R8 one-cycle valid", W'(bank_wvalid), '0);
    chk("R11 wdata hold", bank_wdata, hold);
    issue(FILL, D_BK, 0, S_A, 1, S_BK, 0, 0, 0, '0);
    chk("R8 no-wr valid", W'(bank_wvalid), '0);
    chk("R8 no-wr data", bank_wdata, hold);

    // R3: scalar halves and broadcast
    for (int e = 0; e < 16; e++) begin
      sclm[e] = 16'h1000 + 16'(e * 16'h0111);
      issue(MOV, (e >= 8) ? D_SM : D_SA, 3'(e % 8), S_BK, 0, S_BK, 0, 0, 0, {pat(e+40)[W-1:16], sclm[e]});
    end
    for (int e = 0; e < 16; e++) begin
      issue(MOV, D_B, 7, (e >= 8) ? S_SM : S_SA, 3'(e % 8), S_BK, 0, 0, 0, '0);
      chk("R3 broadcast", res_bus, rep(sclm[e]));
    end
    vecm[15] = rep(sclm[15]);

    // R4: rectify on move and fill
    for (int l = 0; l < 16; l++) v[l*16 +: 16] = (l % 2) ? (16'h8000 | 16'(l * 16'h0111)) : 16'(l * 16'h0123);
    v[31:16] = 16'h8000;
    issue(MOV, D_A, 6, S_BK, 0, S_BK, 0, 1, 0, v);
    chk("R4 move rectified", res_bus, rectify(v));
    vecm[6] = rectify(v);
    peek_vec("R4 stored rectified", 6, vecm[6]);
    issue(FILL, D_BK, 0, S_BK, 0, S_BK, 0, 1, 1, v);
    chk("R4 fill rectified", bank_wdata, rectify(v));
    issue(MOV, D_A, 5, S_BK, 0, S_BK, 0, 0, 0, v);
    chk("R4 no relu passes", res_bus, v);
    vecm[5] = v;
    issue(ADD, D_A, 4, S_BK, 0, S_SA, 0, 1, 0, v);
    chk("R4 relu ignored on add", res_bus, lsum(v, rep(sclm[0])));
    vecm[4] = lsum(v, rep(sclm[0]));

    // R5: arithmetic stub over add, mul, mad into both halves
    for (int i = 0; i < 3; i++) begin
      logic [2:0] op;
      logic [W-1:0] r;
      op = (i == 0) ? ADD : (i == 1) ? MUL : MAD;
      r = lsum(vecm[i], vecm[8+i]);
      issue(op, (i % 2) ? D_B : D_A, 3'(i), S_A, 3'(i), S_B, 3'(i), 0, 0, '0);
      chk("R5 sum", res_bus, r);
      vecm[(i % 2) ? 8+i : i] = r;
    end
    for (int e = 0; e < 16; e++) peek_vec("R5 vector contents", e, vecm[e]);

    // R6: mac ignores dst_sel and lands in half B
    issue(MAC, D_A, 3, S_BK, 0, S_SM, 2, 0, 0, pat(77));
    chk("R6 mac result", res_bus, lsum(pat(77), rep(sclm[10])));
    vecm[11] = lsum(pat(77), rep(sclm[10]));
    peek_vec("R6 half B written", 11, vecm[11]);
    peek_vec("R6 half A untouched", 3, vecm[3]);

    // R7: previous result as a source
    issue(ADD, D_A, 7, S_A, 0, S_A, 1, 0, 0, '0);
    prev = res_bus;
    issue(ADD, D_A, 7, S_RES, 0, S_RES, 0, 0, 0, '0);
    chk("R7 result doubled", res_bus, lsum(prev, prev));
    vecm[7] = lsum(prev, prev);
    prev = res_bus;
    issue(MOV, D_B, 6, S_RES, 0, S_BK, 0, 0, 0, pat(99));
    chk("R7 move of result", res_bus, prev);
    vecm[14] = prev;
    peek_vec("R7 stored", 14, vecm[14]);

    // R9: unreachable destinations
    issue(ADD, D_SA, 1, S_BK, 0, S_BK, 0, 0, 1, pat(5));
    chk("R9 arith to scalar res", res_bus, lsum(pat(5), pat(5)));
    chk("R9 no valid", W'(bank_wvalid), '0);
    issue(MOV, D_B, 7, S_SA, 1, S_BK, 0, 0, 0, '0);
    chk("R9 scalar add 1 unchanged", res_bus, rep(sclm[1]));
    issue(FILL, D_SM, 0, S_BK, 0, S_BK, 0, 0, 0, pat(6));
    issue(MOV, D_B, 7, S_SM, 0, S_BK, 0, 0, 0, '0);
    chk("R9 scalar mul 0 unchanged", res_bus, rep(sclm[8]));
    vecm[15] = rep(sclm[8]);
    hold = bank_wdata;
    issue(MOV, D_BK, 0, S_BK, 0, S_BK, 0, 0, 1, pat(8));
    chk("R9 move to bank no valid", W'(bank_wvalid), '0);
    issue(MUL, D_BK, 0, S_BK, 0, S_BK, 0, 0, 1, pat(9));
    chk("R9 arith to bank no valid", W'(bank_wvalid), '0);
    chk("R11 wdata held", bank_wdata, hold);

    // R10: idle and no-op cycles
    prev = res_bus;
    @(negedge clk);
    op_valid = 0; op_code = MOV; dst_sel = D_A; dst_idx = 0; src0_sel = S_BK; cmd_wr = 1; bank_rdata = pat(123);
    @(posedge clk); #1;
    chk("R10 idle res", res_bus, prev);
    issue(NOP, D_A, 0, S_BK, 0, S_BK, 0, 0, 1, pat(124));
    chk("R10 nop res", res_bus, prev);
    peek_vec("R10 entry unchanged", 0, vecm[0]);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule